// File: doc/BRIEF.md
# Descriptor-Chained Receive DMA Channel

This block is one receive DMA channel. Starting from a descriptor index taken from its control inputs, it reads a descriptor from memory and validates it. It then stores each byte that arrives on a valid/ready stream into the buffer the descriptor names. A descriptor closes in one of three ways: its length runs out, the stream marks end-of-frame before that, or the abort control is raised. On close the channel writes the actual byte count back into the descriptor and clears the descriptor's ready flag. It then either moves on to the next descriptor, wraps to index 0, stops, or parks.

Five sticky event bits record what happened: normal completion, error, not-ready, abort and premature completion. Software clears them by writing 1. They are combined with a mask into a single interrupt line. The same status word also reports the peripheral's FIFO empty and full levels and whether the channel is busy.

A descriptor occupies four 32-bit words at `BASE + 16*index`. Word +0 is the buffer pointer. Word +4 holds the length in bits [15:0]. Word +8 receives the written-back byte count. Word +12 holds the flags: bit 0 ready (F), bit 1 last (L), bit 2 interrupt request (I), bit 3 wrap (W).

Top module: `rx_dma_chan`

## Requirements
- R1: After reset the status event bits [31:27] are 0, `irq` is 0, `rx_ready` is 0 and `mem_req` is 0.
- R2: The n-th accepted byte of a descriptor is written to byte address `ptr + n`, as a word write at `(ptr+n) & ~3` with `mem_be` one-hot on lane `(ptr+n) % 4`.
- R3: When the accepted byte count reaches the length, the descriptor closes normally. The count is written to word +8, the flags word is written back with bit 0 cleared, and status bit 31 is set if flag I (bit 2) is set. An end-of-frame on the final byte still counts as normal.
- R4: If flag I is clear, closing a descriptor by normal or premature completion sets no status bit.
- R5: An end-of-frame before the length is reached closes the descriptor with the partial count. It sets bit 27 if I is set, and the channel continues with the next descriptor without stopping.
- R6: A fetched descriptor with F clear sets bit 29 and parks the channel with `rx_ready` low. Holding `ctrl_ce` high does not restart it. A 0-then-1 toggle of `ctrl_ce` restarts it at `ctrl_idx`.
- R7: A buffer pointer of zero or not word-aligned, or a length of zero, sets bit 30 and parks the channel with the same recovery as R6.
- R8: With `ctrl_ca` high during a transfer, no byte is accepted. The descriptor is closed with its partial count and F cleared, and bit 28 is set. The channel stays idle until `ctrl_ca` is low while `ctrl_ce` is high, then restarts at `ctrl_idx`.
- R9: Writing 1 to a status event bit clears it, and writing 0 leaves it unchanged.
- R10: `irq` is high exactly when some event bit [31:27] is set with the matching bit of `irq_mask` (mask bit 4 to status bit 31, down to mask bit 0 to status bit 27).
- R11: After closing, a descriptor with W (bit 3) set continues at index 0. One with L (bit 1) set stops the channel idle until a `ctrl_ce` toggle. Otherwise the index increments.
- R12: Status bit 16 mirrors `rx_fifo_empty`, bit 17 mirrors `rx_fifo_full`, and bit 18 is high while the channel is fetching, transferring or writing back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_ce | input | 1 | Channel enable |
| ctrl_ca | input | 1 | Channel abort |
| ctrl_idx | input | IDXW | Descriptor index used on (re)start |
| irq_mask | input | 5 | Enables for status bits 31..27 |
| rx_valid | input | 1 | Stream byte valid |
| rx_data | input | 8 | Stream byte |
| rx_eof | input | 1 | Byte is the last of its frame |
| rx_ready | output | 1 | Channel accepts a byte |
| rx_fifo_empty | input | 1 | Peripheral FIFO empty level |
| rx_fifo_full | input | 1 | Peripheral FIFO full level |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_be | output | 4 | Byte lane enables for writes |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| reg_wr | input | 1 | Status register write strobe |
| reg_wdata | input | 32 | Status write data (write 1 to clear) |
| reg_rdata | output | 32 | Status register value |
| irq | output | 1 | Interrupt output |

## Verification
A corrupted descriptor field or a wrong index shows up in memory within a few cycles. A byte can land on the wrong lane, or the write-back can reach words +8 and +12 of a neighbouring descriptor. The bench compares buffer contents and write-back words after every closed descriptor. A wrong parking or restart state shows at the ports within a cycle or two of the triggering condition. It appears as a busy flag that stays high, as `rx_ready` rising while abort is held, or as an unexpected not-ready event when the channel wraps or resumes at an index.

// File: rtl/rx_dma_chan.sv
module rx_dma_chan #(
  parameter int          IDXW = 4,
  parameter int          LENW = 16,
  parameter logic [31:0] BASE = 32'h0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctrl_ce,
  input  logic            ctrl_ca,
  input  logic [IDXW-1:0] ctrl_idx,
  input  logic [4:0]      irq_mask,
  input  logic            rx_valid,
  input  logic [7:0]      rx_data,
  input  logic            rx_eof,
  output logic            rx_ready,
  input  logic            rx_fifo_empty,
  input  logic            rx_fifo_full,
  output logic            mem_req,
  output logic            mem_we,
  output logic [3:0]      mem_be,
  output logic [31:0]     mem_addr,
  output logic [31:0]     mem_wdata,
  input  logic [31:0]     mem_rdata,
  input  logic            reg_wr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            irq
);
  localparam int FB = 0, LB = 1, IB = 2, WB = 3;
  localparam logic [1:0] K_NORM = 2'd0, K_PREM = 2'd1, K_ABRT = 2'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_F0, S_F1, S_F2, S_F3, S_CHK, S_XFER, S_WB1, S_WB2, S_ERR, S_ABT
  } st_t;

  st_t             st;
  logic [IDXW-1:0] idx;
  logic [31:0]     ptr, flg;
  logic [LENW-1:0] len, cnt;
  logic [1:0]      kind;
  logic            ce_q;
  logic [4:0]      pend, hw_set;

  wire [31:0]     daddr   = BASE + (32'(idx) << 4);
  wire [31:0]     baddr   = ptr + 32'(cnt);
  wire [LENW-1:0] cnt_n   = cnt + 1'b1;
  wire            ce_rise = ctrl_ce & ~ce_q;
  wire            take    = rx_valid & rx_ready;
  wire            bad     = (ptr == 32'h0) || (ptr[1:0] != 2'b00) || (len == '0);
  wire            busy    = !(st inside {S_IDLE, S_ERR, S_ABT});
  wire            closing = (st == S_WB2);
  wire [4:0]      clr     = reg_wr ? reg_wdata[31:27] : 5'b0;

  assign rx_ready  = (st == S_XFER) & ~ctrl_ca;
  assign hw_set[4] = closing && kind == K_NORM && flg[IB];
  assign hw_set[3] = (st == S_CHK) && !ctrl_ca && flg[FB] && bad;
  assign hw_set[2] = (st == S_CHK) && !ctrl_ca && !flg[FB];
  assign hw_set[1] = closing && kind == K_ABRT;
  assign hw_set[0] = closing && kind == K_PREM && flg[IB];
  assign reg_rdata = {pend, 8'h00, busy, rx_fifo_full, rx_fifo_empty, 16'h0000};
  assign irq       = |(pend & irq_mask);

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_be    = 4'b0000;
    mem_addr  = daddr;
    mem_wdata = 32'h0;
    case (st)
      S_F0: begin mem_req = 1'b1; mem_addr = daddr + 32'd12; end
      S_F1: begin mem_req = 1'b1; mem_addr = daddr; end
      S_F2: begin mem_req = 1'b1; mem_addr = daddr + 32'd4; end
      S_XFER: begin
        mem_req   = take;
        mem_we    = take;
        mem_be    = 4'b0001 << baddr[1:0];
        mem_addr  = {baddr[31:2], 2'b00};
        mem_wdata = {4{rx_data}};
      end
      S_WB1: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_be = 4'hF;
        mem_addr = daddr + 32'd8; mem_wdata = 32'(cnt);
      end
      S_WB2: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_be = 4'hF;
        mem_addr = daddr + 32'd12; mem_wdata = flg & ~32'h1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      idx  <= '0;
      ptr  <= '0;
      flg  <= '0;
      len  <= '0;
      cnt  <= '0;
      kind <= K_NORM;
      ce_q <= 1'b0;
      pend <= '0;
    end else begin
      ce_q <= ctrl_ce;
      pend <= (pend & ~clr) | hw_set;
      case (st)
        S_IDLE, S_ERR: if (ce_rise) begin idx <= ctrl_idx; st <= S_F0; end
        S_ABT: if (ctrl_ce && !ctrl_ca) begin idx <= ctrl_idx; st <= S_F0; end
        S_F0: begin cnt <= '0; st <= S_F1; end
        S_F1: begin flg <= mem_rdata; st <= S_F2; end
        S_F2: begin ptr <= mem_rdata; st <= S_F3; end
        S_F3: begin len <= mem_rdata[LENW-1:0]; st <= S_CHK; end
        S_CHK:
          if (ctrl_ca)       begin kind <= K_ABRT; st <= S_WB1; end
          else if (!flg[FB]) st <= S_ERR;
          else if (bad)      st <= S_ERR;
          else               st <= S_XFER;
        S_XFER:
          if (ctrl_ca) begin
            kind <= K_ABRT; st <= S_WB1;
          end else if (take) begin
            cnt <= cnt_n;
            if (cnt_n == len)  begin kind <= K_NORM; st <= S_WB1; end
            else if (rx_eof)   begin kind <= K_PREM; st <= S_WB1; end
          end
        S_WB1: st <= S_WB2;
        S_WB2:
          if (kind == K_ABRT)  st <= S_ABT;
          else if (flg[LB])    st <= S_IDLE;
          else begin
            idx <= flg[WB] ? '0 : idx + 1'b1;
            st  <= S_F0;
          end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module rx_dma_chan_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ctrl_ca,
  input logic        rx_ready,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] reg_rdata,
  input logic        irq
);
  a_r8_ready_blocked_by_abort: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> !ctrl_ca);
  a_r8_abort_parks: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_rdata[28]) |-> (!reg_rdata[18] && !rx_ready));
  a_r6_notready_parks: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_rdata[29]) |-> !reg_rdata[18]);
  a_r7_error_parks: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_rdata[30]) |-> !reg_rdata[18]);
  a_r10_irq_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|reg_rdata[31:27]));
  a_r2_write_is_request: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req);
  a_r12_ready_means_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> reg_rdata[18]);
endmodule

bind rx_dma_chan rx_dma_chan_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ctrl_ca(ctrl_ca), .rx_ready(rx_ready),
  .mem_req(mem_req), .mem_we(mem_we), .reg_rdata(reg_rdata), .irq(irq)
);

// File: tb/rx_dma_chan_tb_top.sv
module rx_dma_chan_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 5;
  localparam int V_LEN [NV] = '{4, 8, 5, 6, 3};
  localparam int V_N   [NV] = '{4, 3, 5, 6, 2};
  localparam bit V_EOF [NV] = '{1, 1, 0, 1, 1};
  localparam bit V_I   [NV] = '{1, 1, 0, 1, 0};
  localparam logic [4:0] V_EV [NV] = '{5'b10000, 5'b00001, 5'b00000, 5'b10000, 5'b00000};

  logic clk = 0, rst_n = 0;
  logic ctrl_ce = 0, ctrl_ca = 0;
  logic [3:0] ctrl_idx = 0;
  logic [4:0] irq_mask = 0;
  logic rx_valid = 0, rx_eof = 0, rx_fifo_empty = 0, rx_fifo_full = 0;
  logic [7:0] rx_data = 0;
  logic rx_ready, mem_req, mem_we, irq;
  logic [3:0] mem_be;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, reg_rdata;
  logic reg_wr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] mem [256];
  int checks = 0, fails = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_dma_chan dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_ce(ctrl_ce), .ctrl_ca(ctrl_ca), .ctrl_idx(ctrl_idx),
    .irq_mask(irq_mask), .rx_valid(rx_valid), .rx_data(rx_data), .rx_eof(rx_eof),
    .rx_ready(rx_ready), .rx_fifo_empty(rx_fifo_empty), .rx_fifo_full(rx_fifo_full),
    .mem_req(mem_req), .mem_we(mem_we), .mem_be(mem_be), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  always @(posedge clk) if (mem_req) begin
    if (mem_we) begin
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] = mem_wdata[8*b +: 8];
    end else mem_rdata <= mem[mem_addr[9:2]];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      finish_run();
    end
  end

  task automatic put_desc(input int i, input logic [31:0] p, input logic [31:0] l, input logic [31:0] f);
    mem[i*4] = p; mem[i*4+1] = l; mem[i*4+2] = 32'hDEAD; mem[i*4+3] = f;
  endtask

  task automatic clr_all();
    @(negedge clk); reg_wr = 1; reg_wdata = 32'hFFFF_FFFF;
    @(negedge clk); reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic start(input int i);
    @(negedge clk); ctrl_ce = 0; ctrl_idx = 4'(i);
    @(negedge clk); ctrl_ce = 1;
    @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] d, input logic e);
    @(negedge clk); rx_valid = 1; rx_data = d; rx_eof = e;
    while (!rx_ready) @(negedge clk);
    @(posedge clk); #1; rx_valid = 0; rx_eof = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk); @(negedge clk);
    while (reg_rdata[18] && n < 2000) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  function automatic logic [7:0] rd_byte(input int a);
    return mem[a >> 2][8*(a % 4) +: 8];
  endfunction

  initial begin
    for (int k = 0; k < 256; k++) mem[k] = 0;
    repeat (3) @(negedge clk);
    chk("R1 events", 32'(reg_rdata[31:27]), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 rx_ready", 32'(rx_ready), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 mem_req", 32'(mem_req), 0);

    rx_fifo_empty = 1; rx_fifo_full = 0; @(negedge clk);
    chk("R12 fifo bits", 32'(reg_rdata[18:16]), 32'b001);
    rx_fifo_empty = 0; rx_fifo_full = 1; @(negedge clk);
    chk("R12 fifo bits", 32'(reg_rdata[18:16]), 32'b010);
    rx_fifo_full = 0;

    // vector table: R2 R3 R4 R5 R11
    for (int v = 0; v < NV; v++) begin
      logic [31:0] f;
      f = 32'h3 | (V_I[v] ? 32'h4 : 32'h0);
      put_desc(0, 32'h100, 32'(V_LEN[v]), f);
      clr_all();
      start(0);
      chk("R12 busy while running", 32'(reg_rdata[18]), 1);
      for (int k = 0; k < V_N[v]; k++)
        send_byte(8'(8'hA0 + 16*v + k), V_EOF[v] && (k == V_N[v] - 1));
      wait_idle();
      chk("R3 R5 count written back", mem[2], 32'(V_N[v]));
      chk("R3 F cleared", mem[3], f & ~32'h1);
      chk("R3 R4 R5 events", 32'(reg_rdata[31:27]), 32'(V_EV[v]));
      chk("R11 last stops", 32'(reg_rdata[18]), 0);
      for (int k = 0; k < V_N[v]; k++)
        chk("R2 byte lane", 32'(rd_byte(32'h100 + k)), 32'(8'hA0 + 16*v + k));
    end

    // R6 not ready, CE held, toggle recovery
    put_desc(1, 32'h120, 32'd4, 32'h2);
    clr_all(); start(1); repeat (8) @(negedge clk);
    chk("R6 not-ready event", 32'(reg_rdata[31:27]), 32'b00100);
    chk("R6 parked", 32'(reg_rdata[18]), 0);
    chk("R6 no ready", 32'(rx_ready), 0);
    chk("R6 descriptor untouched", mem[1*4+2], 32'hDEAD);
    put_desc(2, 32'h130, 32'd2, 32'h7);
    ctrl_idx = 2; clr_all(); repeat (10) @(negedge clk);
    chk("R6 no restart with CE held", 32'(reg_rdata[31:18]), 0);
    start(2);
    send_byte(8'h11, 0); send_byte(8'h22, 0);
    wait_idle();
    chk("R6 resumed at index", mem[2*4+2], 2);
    chk("R6 resumed completion", 32'(reg_rdata[31:27]), 32'b10000);

    // R7 bad pointer / length
    put_desc(3, 32'h142, 32'd4, 32'h3);
    clr_all(); start(3); repeat (8) @(negedge clk);
    chk("R7 misaligned ptr", 32'(reg_rdata[31:27]), 32'b01000);
    chk("R7 parked", 32'(reg_rdata[18]), 0);
    put_desc(3, 32'h0, 32'd4, 32'h3);
    clr_all(); start(3); repeat (8) @(negedge clk);
    chk("R7 zero ptr", 32'(reg_rdata[31:27]), 32'b01000);
    put_desc(3, 32'h140, 32'd0, 32'h3);
    clr_all(); start(3); repeat (8) @(negedge clk);
    chk("R7 zero length", 32'(reg_rdata[31:27]), 32'b01000);

    // R10 masking
    irq_mask = 5'b00000; @(negedge clk);
    chk("R10 masked", 32'(irq), 0);
    irq_mask = 5'b10111; @(negedge clk);
    chk("R10 other mask bits", 32'(irq), 0);
    irq_mask = 5'b01000; @(negedge clk);
    chk("R10 enabled", 32'(irq), 1);

    // R9 write-one-to-clear
    @(negedge clk); reg_wr = 1; reg_wdata = 32'h0;
    @(negedge clk); reg_wr = 0;
    chk("R9 write 0 keeps", 32'(reg_rdata[31:27]), 32'b01000);
    @(negedge clk); reg_wr = 1; reg_wdata = 32'h4000_0000;
    @(negedge clk); reg_wr = 0;
    chk("R9 write 1 clears", 32'(reg_rdata[31:27]), 0);
    chk("R10 irq drops", 32'(irq), 0);
    irq_mask = 0;

    // R8 abort
    put_desc(4, 32'h140, 32'd8, 32'h7);
    put_desc(5, 32'h150, 32'd4, 32'h0);
    clr_all(); start(4);
    send_byte(8'h31, 0); send_byte(8'h32, 0);
    @(negedge clk); ctrl_ca = 1;
    wait_idle();
    chk("R8 abort event", 32'(reg_rdata[31:27]), 32'b00010);
    chk("R8 partial count", mem[4*4+2], 2);
    chk("R8 F cleared", mem[4*4+3], 32'h6);
    chk("R8 no ready", 32'(rx_ready), 0);
    ctrl_idx = 5; repeat (6) @(negedge clk);
    chk("R8 held while abort set", 32'(reg_rdata[18]), 0);
    ctrl_ca = 0; repeat (8) @(negedge clk);
    chk("R8 restart at index", 32'(reg_rdata[31:27]), 32'b00110);

    // R5 continue + R11 chain and wrap
    put_desc(6, 32'h180, 32'd4, 32'h5);
    put_desc(7, 32'h1A0, 32'd2, 32'hD);
    mem[3] = 32'h0;
    clr_all(); start(6);
    send_byte(8'h41, 0); send_byte(8'h42, 1);
    send_byte(8'h51, 0); send_byte(8'h52, 0);
    wait_idle();
    chk("R5 premature count", mem[6*4+2], 2);
    chk("R11 next descriptor", mem[7*4+2], 2);
    chk("R5 R11 events", 32'(reg_rdata[31:27]), 32'b10101);
    chk("R11 wrap fetched index 0", mem[2], 32'(V_N[NV-1]));
    chk("R2 chained data", 32'(rd_byte(32'h1A1)), 32'h52);

    finish_run();
  end
endmodule